// File: doc/BRIEF.md
# Peripheral Security Access Gate

This block stands between an APB-style upstream requester and sixteen downstream peripheral ports. For every transfer it compares the protection attributes of the request with two permission inputs for the selected port. One input covers non-secure access and the other covers unprivileged access. A permitted transfer goes to that port alone, and the port's response is passed back upstream unchanged. A refused transfer never reaches any peripheral. The gate completes it locally, either with an error response or as a read of zero with the write data discarded.

Nothing inside the block is software-programmable. All permissions come from input wires, which are usually driven by a secure system controller. An elaboration-time mask lists ports that skip the security check. Address decoding stays outside the block, and the system supplies one select line per port. Each refusal sets a sticky pending flag. The flag drives an interrupt output through an enable input and is cleared by a clear input.

Top module: `secAccessGate`

## Requirements
- R1: A permitted transfer asserts the downstream select and enable of the selected port only. Address, write flag, write data, strobes and protection go out unchanged.
- R2: During a permitted transfer, read data, ready and error of the selected port appear unchanged on the upstream outputs, including a ready held low.
- R3: A transfer with protection bit 1 set (non-secure) is refused when the selected port's non-secure permission bit is 0. It is permitted when that bit is 1.
- R4: A transfer with protection bit 0 clear (unprivileged) is refused when the selected port's unprivileged permission bit is 0. It is permitted when that bit is 1.
- R5: A refused transfer asserts no downstream select or enable on any port.
- R6: A refused transfer completes in its access cycle with ready 1 and read data 0. Its error output equals the response-mode input (1 = error, 0 = read-as-zero/write-ignored).
- R7: For a port whose bit is set in the exemption mask parameter, the non-secure permission input has no effect. The unprivileged check still applies to that port.
- R8: A transfer with more than one select line active is refused with error 1, whatever the response mode.
- R9: The pending flag sets on the clock edge that ends the access cycle of a refused transfer. It stays set through later permitted transfers.
- R10: The interrupt output equals pending AND enable. A clear input that is high at an edge empties the pending flag, and it wins over a refusal at the same edge.
- R11: Reset empties the pending flag, so the interrupt output is 0 after reset even with the enable input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selIn | input | 16 | Per-port select from external decode |
| enableIn | input | 1 | Access-phase strobe |
| addrIn | input | 32 | Transfer address |
| writeIn | input | 1 | 1 = write |
| wdataIn | input | 32 | Write data |
| strbIn | input | 4 | Write byte strobes |
| protIn | input | 3 | Protection: bit 0 privileged, bit 1 non-secure |
| rdataOut | output | 32 | Read data upstream |
| readyOut | output | 1 | Transfer ready upstream |
| slvErrOut | output | 1 | Transfer error upstream |
| dnSel | output | 16 | Per-port downstream select |
| dnEnable | output | 16 | Per-port downstream enable |
| dnAddr | output | 32 | Shared downstream address |
| dnWrite | output | 1 | Shared downstream write flag |
| dnWdata | output | 32 | Shared downstream write data |
| dnStrb | output | 4 | Shared downstream strobes |
| dnProt | output | 3 | Shared downstream protection |
| dnRdata | input | 512 | Read data of all ports, port n at bits n*32 upward |
| dnReady | input | 16 | Per-port ready |
| dnErr | input | 16 | Per-port error |
| cfgNonSecOk | input | 16 | Per-port non-secure permission |
| cfgUnprivOk | input | 16 | Per-port unprivileged permission |
| cfgErrResp | input | 1 | Refusal mode: 1 error, 0 read-zero/write-ignore |
| irqEn | input | 1 | Interrupt enable |
| irqClr | input | 1 | Pending-flag clear |
| irqOut | output | 1 | Rejection interrupt |

## Verification
The assertions check on every cycle that a refusal never reaches a peripheral. They also check that a refusal completes at once with zero data and the chosen error, and that multi-select refusals always report an error. The remaining per-cycle checks are that downstream selects stay one-hot within the upstream selects, that enables imply selects, and that the interrupt follows the set, clear and enable rules. Only the bench scenarios can show that each attribute and permission combination gives the right decision, that exempted ports ignore the non-secure permission, that read data and wait states come from the correct port, and that the pending flag stays set across later permitted traffic.

// File: rtl/gatePkg.sv
package gatePkg;
  // Decision strobes handed from the control to the datapath
  typedef struct packed {
    logic fwd;      // transfer goes to the selected port
    logic refuse;   // transfer completes locally
    logic errResp;  // error flag for a local completion
  } gateStrb_t;
endpackage

// File: rtl/accessCtl.sv
module accessCtl
  import gatePkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter logic [NUM_PORTS-1:0] EXEMPT_MASK = '0,
  localparam int IDX_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] selIn,
  input  logic                 enableIn,
  input  logic [2:0]           protIn,
  input  logic [NUM_PORTS-1:0] cfgNonSecOk,
  input  logic [NUM_PORTS-1:0] cfgUnprivOk,
  input  logic                 cfgErrResp,
  input  logic                 irqEn,
  input  logic                 irqClr,
  output gateStrb_t            strb,
  output logic [IDX_W-1:0]     portIdx,
  output logic                 irqOut
);
  logic anySel, multiSel, nsFail, privFail, refuse, pending;

  // OR-encoder: exact when exactly one select is active
  always_comb begin
    portIdx = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (selIn[i]) portIdx = portIdx | IDX_W'(i);
  end

  assign anySel   = |selIn;
  assign multiSel = (selIn & (selIn - 1'b1)) != '0;
  assign nsFail   = protIn[1] && !cfgNonSecOk[portIdx] && !EXEMPT_MASK[portIdx];
  assign privFail = !protIn[0] && !cfgUnprivOk[portIdx];
  assign refuse   = anySel && (multiSel || nsFail || privFail);

  assign strb.fwd     = anySel && !refuse;
  assign strb.refuse  = refuse;
  assign strb.errResp = multiSel || cfgErrResp;

  // Sticky rejection flag, clear has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pending <= 1'b0;
    else if (irqClr)             pending <= 1'b0;
    else if (enableIn && refuse) pending <= 1'b1;
  end

  assign irqOut = pending && irqEn;

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    irqClr |=> !irqOut);
  a_r9_refusal_sets: assert property (@(posedge clk) disable iff (!rstN)
    (enableIn && refuse && !irqClr) |=> (irqOut == irqEn));
endmodule

// File: rtl/gateDatapath.sv
module gateDatapath
  import gatePkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_PORTS),
  localparam int STRB_W = DATA_W / 8
) (
  input  gateStrb_t                   strb,
  input  logic [IDX_W-1:0]            portIdx,
  input  logic [NUM_PORTS-1:0]        selIn,
  input  logic                        enableIn,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic                        writeIn,
  input  logic [DATA_W-1:0]           wdataIn,
  input  logic [STRB_W-1:0]           strbIn,
  input  logic [2:0]                  protIn,
  output logic [DATA_W-1:0]           rdataOut,
  output logic                        readyOut,
  output logic                        slvErrOut,
  output logic [NUM_PORTS-1:0]        dnSel,
  output logic [NUM_PORTS-1:0]        dnEnable,
  output logic [ADDR_W-1:0]           dnAddr,
  output logic                        dnWrite,
  output logic [DATA_W-1:0]           dnWdata,
  output logic [STRB_W-1:0]           dnStrb,
  output logic [2:0]                  dnProt,
  input  logic [NUM_PORTS*DATA_W-1:0] dnRdata,
  input  logic [NUM_PORTS-1:0]        dnReady,
  input  logic [NUM_PORTS-1:0]        dnErr
);
  logic [DATA_W-1:0] rdArr [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_unpack
    assign rdArr[g] = dnRdata[g*DATA_W +: DATA_W];
  end

  assign dnSel    = strb.fwd ? selIn : '0;
  assign dnEnable = dnSel & {NUM_PORTS{enableIn}};
  assign dnAddr   = addrIn;
  assign dnWrite  = writeIn;
  assign dnWdata  = wdataIn;
  assign dnStrb   = strbIn;
  assign dnProt   = protIn;

  always_comb begin
    rdataOut  = '0;
    readyOut  = 1'b1;
    slvErrOut = 1'b0;
    if (strb.fwd) begin
      rdataOut  = rdArr[portIdx];
      readyOut  = dnReady[portIdx];
      slvErrOut = dnErr[portIdx];
    end else if (strb.refuse) begin
      slvErrOut = strb.errResp;
    end
  end
endmodule

// File: rtl/secAccessGate.sv
module secAccessGate
  import gatePkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [NUM_PORTS-1:0] EXEMPT_MASK = '0,
  localparam int IDX_W = $clog2(NUM_PORTS),
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        selIn,
  input  logic                        enableIn,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic                        writeIn,
  input  logic [DATA_W-1:0]           wdataIn,
  input  logic [STRB_W-1:0]           strbIn,
  input  logic [2:0]                  protIn,
  output logic [DATA_W-1:0]           rdataOut,
  output logic                        readyOut,
  output logic                        slvErrOut,
  output logic [NUM_PORTS-1:0]        dnSel,
  output logic [NUM_PORTS-1:0]        dnEnable,
  output logic [ADDR_W-1:0]           dnAddr,
  output logic                        dnWrite,
  output logic [DATA_W-1:0]           dnWdata,
  output logic [STRB_W-1:0]           dnStrb,
  output logic [2:0]                  dnProt,
  input  logic [NUM_PORTS*DATA_W-1:0] dnRdata,
  input  logic [NUM_PORTS-1:0]        dnReady,
  input  logic [NUM_PORTS-1:0]        dnErr,
  input  logic [NUM_PORTS-1:0]        cfgNonSecOk,
  input  logic [NUM_PORTS-1:0]        cfgUnprivOk,
  input  logic                        cfgErrResp,
  input  logic                        irqEn,
  input  logic                        irqClr,
  output logic                        irqOut
);
  gateStrb_t        strb;
  logic [IDX_W-1:0] portIdx;

  accessCtl #(.NUM_PORTS(NUM_PORTS), .EXEMPT_MASK(EXEMPT_MASK)) u_ctl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn), .protIn(protIn),
    .cfgNonSecOk(cfgNonSecOk), .cfgUnprivOk(cfgUnprivOk), .cfgErrResp(cfgErrResp),
    .irqEn(irqEn), .irqClr(irqClr), .strb(strb), .portIdx(portIdx), .irqOut(irqOut)
  );

  gateDatapath #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .strb(strb), .portIdx(portIdx), .selIn(selIn), .enableIn(enableIn),
    .addrIn(addrIn), .writeIn(writeIn), .wdataIn(wdataIn), .strbIn(strbIn),
    .protIn(protIn), .rdataOut(rdataOut), .readyOut(readyOut), .slvErrOut(slvErrOut),
    .dnSel(dnSel), .dnEnable(dnEnable), .dnAddr(dnAddr), .dnWrite(dnWrite),
    .dnWdata(dnWdata), .dnStrb(dnStrb), .dnProt(dnProt), .dnRdata(dnRdata),
    .dnReady(dnReady), .dnErr(dnErr)
  );

  a_r5_refusal_blocked: assert property (@(posedge clk) disable iff (!rstN)
    strb.refuse |-> (dnSel == '0 && dnEnable == '0));
  a_r6_refusal_completes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refuse && enableIn) |-> (readyOut && rdataOut == '0
      && slvErrOut == (cfgErrResp || $countones(selIn) > 1)));
  a_r8_multi_error: assert property (@(posedge clk) disable iff (!rstN)
    (enableIn && $countones(selIn) > 1) |-> (dnSel == '0 && slvErrOut && readyOut));
  a_r1_single_port: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dnSel) && ((dnSel & ~selIn) == '0) && ((dnEnable & ~dnSel) == '0));
  a_r10_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);
endmodule

// File: tb/test_secAccessGate.sv
module test_secAccessGate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] selIn = '0;
  logic enableIn = 1'b0;
  logic [31:0] addrIn = '0;
  logic writeIn = 1'b0;
  logic [31:0] wdataIn = '0;
  logic [3:0] strbIn = '0;
  logic [2:0] protIn = '0;
  logic [31:0] rdataOut;
  logic readyOut, slvErrOut;
  logic [15:0] dnSel, dnEnable;
  logic [31:0] dnAddr, dnWdata;
  logic dnWrite;
  logic [3:0] dnStrb;
  logic [2:0] dnProt;
  logic [511:0] dnRdata;
  logic [15:0] dnReady = 16'hFFFF;
  logic [15:0] dnErr = 16'h0020;       // port 5 answers with error
  logic [15:0] cfgNonSecOk = '0, cfgUnprivOk = '0;
  logic cfgErrResp = 1'b0, irqEn = 1'b0, irqClr = 1'b0, irqOut;

  int total = 0, bad = 0;
  logic [31:0] sRdata, sAddr, sWdata;
  logic [15:0] sSel, sEn;
  logic sReady, sErr;
  logic [2:0] sProt;

  always #5 clk = ~clk;

  initial for (int i = 0; i < 16; i++) dnRdata[i*32 +: 32] = 32'hA500_0000 | i;

  secAccessGate #(.EXEMPT_MASK(16'h0100)) i_secAccessGate (.*);

  // {sel, prot, nonsecOk, unprivOk, mode, expFwd, expErr}
  localparam logic [53:0] VEC [12] = '{
    {16'h0001, 3'b001, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'h0020, 3'b011, 16'h0020, 16'h0000, 1'b0, 1'b1, 1'b1},
    {16'h0008, 3'b011, 16'hFFF7, 16'hFFFF, 1'b1, 1'b0, 1'b1},
    {16'h0008, 3'b011, 16'hFFF7, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {16'h0004, 3'b000, 16'hFFFF, 16'hFFFB, 1'b1, 1'b0, 1'b1},
    {16'h0004, 3'b000, 16'h0000, 16'h0004, 1'b1, 1'b1, 1'b0},
    {16'h8000, 3'b010, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0},
    {16'h8000, 3'b010, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h0100, 3'b011, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'h0100, 3'b010, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h0200, 3'b011, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {16'h0011, 3'b001, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1}
  };
  string tagOf [12] = '{"R1", "R2", "R3", "R6", "R4", "R4", "R3", "R4", "R7", "R7", "R7", "R8"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] s, input logic [2:0] p);
    @(negedge clk);
    selIn = s; protIn = p; enableIn = 1'b0;
    addrIn = 32'h4000_0000 + total; wdataIn = 32'h1234_0000 + total;
    writeIn = ~writeIn; strbIn = 4'hA;
    @(negedge clk);
    enableIn = 1'b1;
    #2;
    sSel = dnSel; sEn = dnEnable; sRdata = rdataOut; sReady = readyOut; sErr = slvErrOut;
    sAddr = dnAddr; sWdata = dnWdata; sProt = dnProt;
    @(negedge clk);
    selIn = '0; enableIn = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    irqEn = 1'b1;
    #1; check(irqOut == 1'b0, "R11 irq in reset", 32'(irqOut), 0);
    #22 rstN = 1'b1;
    @(negedge clk);
    check(irqOut == 1'b0 && dnSel == '0, "R11 after reset", 32'(irqOut), 0);

    // Table walk
    for (int v = 0; v < 12; v++) begin
      logic [15:0] s;
      int port;
      s = VEC[v][53:38];
      cfgNonSecOk = VEC[v][34:19];
      cfgUnprivOk = VEC[v][18:3];
      cfgErrResp = VEC[v][2];
      port = 0;
      for (int i = 0; i < 16; i++) if (s[i]) port = i;
      xfer(s, VEC[v][37:35]);
      if (VEC[v][1]) begin
        check(sSel == s && sEn == s, {tagOf[v], " R1 forward sel"}, 32'(sSel), 32'(s));
        check(sAddr == addrIn && sWdata == wdataIn && sProt == VEC[v][37:35],
              {tagOf[v], " R1 shared fields"}, sAddr, addrIn);
        check(sRdata == (32'hA500_0000 | port) && sReady,
              {tagOf[v], " R2 return data"}, sRdata, 32'hA500_0000 | port);
      end else begin
        check(sSel == '0 && sEn == '0, {tagOf[v], " R5 no forward"}, 32'(sSel), 0);
        check(sRdata == '0 && sReady, {tagOf[v], " R6 zero data"}, sRdata, 0);
      end
      check(sErr == VEC[v][0], {tagOf[v], " R6 error flag"}, 32'(sErr), 32'(VEC[v][0]));
    end

    // R2: wait state from the selected port
    cfgNonSecOk = '1; cfgUnprivOk = '1; dnReady = 16'hFFFD;
    xfer(16'h0002, 3'b001);
    check(sReady == 1'b0, "R2 wait state", 32'(sReady), 0);
    dnReady = 16'hFFFF;

    // Interrupt behaviour
    @(negedge clk); irqEn = 1'b0; irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    check(irqOut == 1'b0, "R10 masked", 32'(irqOut), 0);
    irqEn = 1'b1; #1;
    check(irqOut == 1'b0, "R10 cleared", 32'(irqOut), 0);
    cfgNonSecOk = 16'hFFF7;
    xfer(16'h0008, 3'b011);
    check(irqOut == 1'b1, "R9 set on refusal", 32'(irqOut), 1);
    xfer(16'h0001, 3'b011);
    check(irqOut == 1'b1, "R9 sticky", 32'(irqOut), 1);
    irqEn = 1'b0; #1;
    check(irqOut == 1'b0, "R10 enable gates", 32'(irqOut), 0);
    irqEn = 1'b1; #1;
    check(irqOut == 1'b1, "R10 pending kept", 32'(irqOut), 1);
    irqClr = 1'b1;
    xfer(16'h0008, 3'b011);
    check(irqOut == 1'b0, "R10 clear wins", 32'(irqOut), 0);
    irqClr = 1'b0;
    @(negedge clk);
    check(irqOut == 1'b0, "R10 stays clear", 32'(irqOut), 0);

    // R11: reset empties a pending flag
    xfer(16'h0008, 3'b011);
    check(irqOut == 1'b1, "R9 set again", 32'(irqOut), 1);
    rstN = 1'b0; #2;
    check(irqOut == 1'b0, "R11 reset clears", 32'(irqOut), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(irqOut == 1'b0, "R11 after release", 32'(irqOut), 0);
    finishRun();
  end
endmodule